// File: doc/BRIEF.md
# Call Return Stack with Fault Reset

This block holds return addresses for a small soft processor. Subroutine calls and interrupt entries both push the current program counter onto it. Subroutine returns and returns from interrupt both pop from it. There is a single push/pop interface, so an interrupt nested inside a subroutine, or the other way round, unwinds in strict last-in-first-out order. The processor reads the return target from `top_addr_o` in the same cycle that it asserts `pop_i`.

A mode input selects between two behaviours. In wrap mode the storage is a ring, and misuse is silent. Extra pushes overwrite the oldest entries, and extra pops hand back stale addresses. In bounded mode the storage is a linear stack of 30 entries. A push into a full stack, or a pop from an empty one, does not change the stack. Instead, the block emits a one-cycle reset request that the surrounding logic feeds to the processor's reset. Software can force a controlled restart this way, and a runaway call chain ends in a known state.

Top module: `call_ret_stack`

## Requirements
- R1: A synchronous reset clears the depth to 0 and holds `fault_rst_o` low. Stored addresses are kept.
- R2: A push stores `push_addr_i`, which then appears on `top_addr_o`, and the depth rises by one. A pop removes the top entry, exposes the one below it, and lowers the depth by one.
- R3: In wrap mode, a push when 30 entries are held overwrites the oldest entry and raises no reset request.
- R4: In wrap mode, a pop with depth 0 still moves the stack pointer down and exposes a stale stored address. The depth stays 0 and no reset request is raised.
- R5: In wrap mode, the depth output saturates at 30 however many further pushes occur.
- R6: In bounded mode, 30 pushes in a row are accepted without a reset request.
- R7: In bounded mode, a push while 30 entries are held raises the reset request and does not store the address. The top address and the depth stay as they were.
- R8: In bounded mode, a pop with depth 0 (alone or together with a push) raises the reset request and leaves the depth at 0.
- R9: A push and a pop in the same cycle replace the top entry with `push_addr_i` and leave the depth unchanged.
- R10: The reset request is high for exactly the one cycle after the clock edge that samples the faulting operation. It returns low on the next edge if no further fault occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push request (call or interrupt entry) |
| pop_i | input | 1 | Pop request (return or return from interrupt) |
| push_addr_i | input | 12 | Return address to store |
| bounded_i | input | 1 | 1 = bounded linear mode, 0 = wrap ring mode |
| top_addr_o | output | 12 | Address at the top of the stack |
| depth_o | output | 5 | Number of held entries, 0 to 30 |
| fault_rst_o | output | 1 | One-cycle processor reset request on overflow or underflow |

## Verification
The hardest case to reach is the stale return in wrap mode. Its value depends on what earlier traffic left in the slots below the pointer, and a reset does not clear those slots. The stimulus first pushes 31 known addresses so that the ring wraps and every slot holds a predictable value. It then resets the pointer, pushes and pops past empty, and compares the exposed addresses with the entries from that earlier pass. The bounded faults are reached by filling the stack to exactly 30 entries and then issuing one more push, and by draining it fully and then issuing one more pop.

// File: rtl/rsk_pkg.sv
`timescale 1ns/1ps
package rsk_pkg;
   typedef enum logic [1:0] {
      RSK_IDLE = 2'b00,
      RSK_PUSH = 2'b01,
      RSK_POP  = 2'b10,
      RSK_SWAP = 2'b11
   } rsk_op_e;

   function automatic rsk_op_e rsk_decode(input logic push, input logic pop);
      rsk_decode = rsk_op_e'({pop, push});
   endfunction
endpackage

// File: rtl/rsk_ctrl.sv
`timescale 1ns/1ps
module rsk_ctrl
   import rsk_pkg::*;
#(
   parameter int DEPTH = 30,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  rsk_op_e          op_i,
   input  logic             bounded_i,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_idx_o,
   output logic [PTR_W-1:0] rd_idx_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fault_o
);
   localparam bit POW2 = ((1 << PTR_W) == DEPTH);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [PTR_W-1:0] head_q, head_d, head_inc, head_dec;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             fault_q, fault_d;
   logic             full, empty;

   generate
      if (POW2) begin : g_ring_pow2
         assign head_inc = head_q + 1'b1;
         assign head_dec = head_q - 1'b1;
      end else begin : g_ring_mod
         assign head_inc = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
         assign head_dec = (head_q == '0) ? PTR_W'(DEPTH - 1) : head_q - 1'b1;
      end
   endgenerate

   assign full  = (cnt_q == CNT_FULL);
   assign empty = (cnt_q == '0);

   always_comb begin
      head_d   = head_q;
      cnt_d    = cnt_q;
      fault_d  = 1'b0;
      wr_en_o  = 1'b0;
      wr_idx_o = head_q;
      case (op_i)
         RSK_PUSH: begin
            if (bounded_i && full) begin
               fault_d = 1'b1;
            end else begin
               wr_en_o = 1'b1;
               head_d  = head_inc;
               cnt_d   = full ? cnt_q : cnt_q + 1'b1;
            end
         end
         RSK_POP: begin
            if (bounded_i && empty) begin
               fault_d = 1'b1;
            end else begin
               head_d = head_dec;
               cnt_d  = empty ? cnt_q : cnt_q - 1'b1;
            end
         end
         RSK_SWAP: begin
            if (bounded_i && empty) begin
               fault_d = 1'b1;
            end else begin
               wr_en_o  = 1'b1;
               wr_idx_o = head_dec;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q  <= '0;
         cnt_q   <= '0;
         fault_q <= 1'b0;
      end else begin
         head_q  <= head_d;
         cnt_q   <= cnt_d;
         fault_q <= fault_d;
      end
   end

   assign rd_idx_o = head_dec;
   assign cnt_o    = cnt_q;
   assign fault_o  = fault_q;
endmodule

// File: rtl/rsk_store.sv
`timescale 1ns/1ps
module rsk_store #(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 30,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_idx_i,
   output logic [ADDR_W-1:0] rd_data_o
);
   logic [ADDR_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) slot_q[wr_idx_i] <= wr_data_i;
   end

   assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/call_ret_stack.sv
`timescale 1ns/1ps
module call_ret_stack
   import rsk_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 30,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic              bounded_i,
   output logic [ADDR_W-1:0] top_addr_o,
   output logic [CNT_W-1:0]  depth_o,
   output logic              fault_rst_o
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("call_ret_stack: DEPTH must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_width
         $error("call_ret_stack: ADDR_W must be at least 1");
      end
   endgenerate

   rsk_op_e          op;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx, rd_idx;

   assign op = rsk_decode(push_i, pop_i);

   rsk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .op_i      (op),
      .bounded_i (bounded_i),
      .wr_en_o   (wr_en),
      .wr_idx_o  (wr_idx),
      .rd_idx_o  (rd_idx),
      .cnt_o     (depth_o),
      .fault_o   (fault_rst_o)
   );

   rsk_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .wr_en_i   (wr_en),
      .wr_idx_i  (wr_idx),
      .wr_data_i (push_addr_i),
      .rd_idx_i  (rd_idx),
      .rd_data_o (top_addr_o)
   );
endmodule

// File: rtl/call_ret_stack_chk.sv
`timescale 1ns/1ps
module call_ret_stack_chk #(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 30,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              push_i,
   input logic              pop_i,
   input logic [ADDR_W-1:0] push_addr_i,
   input logic              bounded_i,
   input logic [ADDR_W-1:0] top_addr_o,
   input logic [CNT_W-1:0]  depth_o,
   input logic              fault_rst_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (rst)
      depth_o <= FULL); // R5
   AST_WRAP_SILENT: assert property (@(posedge clk) disable iff (rst)
      !bounded_i |=> !fault_rst_o); // R3
   AST_OVERFLOW_RESET: assert property (@(posedge clk) disable iff (rst)
      (bounded_i && push_i && !pop_i && depth_o == FULL)
      |=> (fault_rst_o && depth_o == FULL && $stable(top_addr_o))); // R7
   AST_UNDERFLOW_RESET: assert property (@(posedge clk) disable iff (rst)
      (bounded_i && pop_i && depth_o == '0) |=> (fault_rst_o && depth_o == '0)); // R8
   AST_SWAP_DEPTH: assert property (@(posedge clk) disable iff (rst)
      (push_i && pop_i && !(bounded_i && depth_o == '0))
      |=> ($stable(depth_o) && !fault_rst_o)); // R9
   AST_PUSH_TOP: assert property (@(posedge clk) disable iff (rst)
      (push_i && !(bounded_i && !pop_i && depth_o == FULL)
       && !(bounded_i && pop_i && depth_o == '0))
      |=> top_addr_o == $past(push_addr_i)); // R2
   AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
      (!push_i && !pop_i) |=> !fault_rst_o); // R10
endmodule

bind call_ret_stack call_ret_stack_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .push_addr_i (push_addr_i),
   .bounded_i   (bounded_i),
   .top_addr_o  (top_addr_o),
   .depth_o     (depth_o),
   .fault_rst_o (fault_rst_o)
);

// File: tb/tb_call_ret_stack.sv
`timescale 1ns/1ps
module tb_call_ret_stack;
   logic        clk = 1'b0;
   logic        rst = 1'b0;
   logic        push = 1'b0;
   logic        pop = 1'b0;
   logic [11:0] addr = '0;
   logic        bounded = 1'b0;
   logic [11:0] top;
   logic [4:0]  depth;
   logic        fault;
   int          checks = 0;
   int          errors = 0;

   always #2.5 clk = ~clk;

   call_ret_stack dut (
      .clk(clk), .rst(rst), .push_i(push), .pop_i(pop), .push_addr_i(addr),
      .bounded_i(bounded), .top_addr_o(top), .depth_o(depth), .fault_rst_o(fault)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic p, input logic q, input logic [11:0] a);
      @(negedge clk);
      push = p; pop = q; addr = a;
      @(posedge clk); #1;
      push = 1'b0; pop = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1; rst = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(depth == 0, "R1 depth after reset", depth, 0);
      chk(fault == 1'b0, "R1 fault after reset", fault, 0);
   endtask

   task automatic t_lifo();
      bounded = 1'b0; do_reset();
      cyc(1, 0, 12'h0A1); cyc(1, 0, 12'h0B2); cyc(1, 0, 12'h0C3);
      chk(top == 12'h0C3 && depth == 3, "R2 top after pushes", top, 12'h0C3);
      cyc(0, 1, '0);
      chk(top == 12'h0B2 && depth == 2, "R2 top after pop", top, 12'h0B2);
      cyc(0, 1, '0);
      chk(top == 12'h0A1 && depth == 1, "R2 second pop", top, 12'h0A1);
   endtask

   task automatic t_wrap_over();
      int seen_fault = 0;
      int bad = 0;
      bounded = 1'b0; do_reset();
      for (int i = 1; i <= 31; i++) begin
         cyc(1, 0, 12'h100 + 12'(i));
         if (fault) seen_fault++;
      end
      chk(depth == 30, "R5 depth saturates", depth, 30);
      chk(seen_fault == 0, "R3 no fault on wrap overflow", seen_fault, 0);
      for (int k = 0; k < 30; k++) begin
         if (top != 12'h100 + 12'(31 - k)) bad++;
         cyc(0, 1, '0);
      end
      chk(bad == 0, "R3 newest entries pop in order", bad, 0);
      chk(top == 12'h11F, "R3 oldest entry overwritten", top, 12'h11F);
      chk(depth == 0, "R2 depth after draining", depth, 0);
   endtask

   task automatic t_wrap_under();
      bounded = 1'b0; do_reset();
      cyc(1, 0, 12'hA0A); cyc(1, 0, 12'hB0B);
      cyc(0, 1, '0); cyc(0, 1, '0);
      chk(top == 12'h11E, "R4 stale top at empty", top, 12'h11E);
      cyc(0, 1, '0);
      chk(top == 12'h11D, "R4 stale top after underflow", top, 12'h11D);
      chk(depth == 0 && !fault, "R4 depth 0 and no fault", depth, 0);
   endtask

   task automatic t_swap();
      bounded = 1'b0; do_reset();
      cyc(1, 0, 12'h111); cyc(1, 0, 12'h222);
      cyc(1, 1, 12'h333);
      chk(top == 12'h333, "R9 top replaced", top, 12'h333);
      chk(depth == 2, "R9 depth unchanged", depth, 2);
      cyc(0, 1, '0);
      chk(top == 12'h111, "R9 entry below intact", top, 12'h111);
   endtask

   task automatic t_bounded();
      int seen_fault = 0;
      bounded = 1'b1; do_reset();
      for (int i = 0; i < 30; i++) begin
         cyc(1, 0, 12'h200 + 12'(i));
         if (fault) seen_fault++;
      end
      chk(seen_fault == 0 && depth == 30, "R6 thirty pushes accepted", seen_fault, 0);
      cyc(1, 0, 12'h7FF);
      chk(fault == 1'b1, "R7 overflow raises reset", fault, 1);
      chk(top == 12'h21D && depth == 30, "R7 address not stored", top, 12'h21D);
      @(posedge clk); #1;
      chk(fault == 1'b0, "R10 pulse lasts one cycle", fault, 0);
      for (int i = 0; i < 30; i++) cyc(0, 1, '0);
      chk(depth == 0 && !fault, "R2 bounded drain", depth, 0);
      cyc(0, 1, '0);
      chk(fault == 1'b1 && depth == 0, "R8 underflow raises reset", fault, 1);
      @(posedge clk); #1;
      chk(fault == 1'b0, "R10 underflow pulse ends", fault, 0);
      cyc(1, 1, 12'h555);
      chk(fault == 1'b1 && depth == 0, "R8 swap on empty raises reset", fault, 1);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_lifo();
      t_wrap_over();
      t_wrap_under();
      t_swap();
      t_bounded();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule